// File: doc/BRIEF.md
# Four-Phase Debug Register Target

This block is a target on a narrow debug bus that uses a fully interlocked request/acknowledge handshake. A requester raises `req_i` and, in the same cycle, presents an 8-bit address, 64 bits of write data and a write flag. The target samples these on the first clock edge that sees the request. It performs the access once, raises `ack_o` one clock later and keeps it high, together with stable read data, for as long as the request stays high. When the request falls, the acknowledge falls on the next clock. The block is then ready for the next transaction.

Eight 64-bit read/write registers sit at addresses 0 through 7. Any higher address is unmapped. A read of an unmapped address returns zero, and a write to one changes nothing, but both still complete the handshake. The upstream side may stall with the request held high for any length of time. During such a stall the target neither repeats the access nor reacts to changes on the address or data inputs.

Top module: `dbg_reg_target`

## Requirements
- R1: Address, write data and write flag are sampled on the clock edge where `req_i` is first seen high in the idle state. A write updates the addressed register exactly once per request, at that edge.
- R2: `ack_o` goes high on the clock edge after the request is accepted.
- R3: While `req_i` stays high, `ack_o` stays high for any number of cycles. Changes on `addr_i`, `wdata_i` or `wr_i` during that time have no effect on any register.
- R4: `rdata_o` does not change during any cycle in which `ack_o` is high and was already high in the previous cycle.
- R5: `ack_o` goes low on the clock edge after `req_i` is seen low. It stays low while `req_i` remains low.
- R6: A new request raised one clock after `ack_o` is observed low is accepted and handled like any other.
- R7: A read of any address from 0x08 to 0xFF returns zero on `rdata_o` and completes the handshake. A write to such an address alters none of the eight registers.
- R8: Register n (n = 0..7) is selected by `addr_i` = n. A read returns the last value written to that register, and each register is independent of the others.
- R9: While `rst_n` is low, `ack_o` and `rdata_o` are zero. After reset, every register reads zero.
- R10: During the acknowledge of a write (`wr_i` = 1), `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, is released synchronously upstream |
| req_i | input | 1 | Transaction request from the requester |
| addr_i | input | 8 | Register address, valid with the rising request |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 64 | Write data, valid with the rising request |
| ack_o | output | 1 | Acknowledge, held until the request falls |
| rdata_o | output | 64 | Read data, held while acknowledge is high |

## Verification
The bound checker watches the handshake on every cycle:
- acknowledge holds while the request is high, and falls one clock after the request falls;
- acknowledge rises only after a cycle with the request high;
- read data stays frozen through the acknowledge;
- the outputs are quiet during reset.

Whether a register changed once and only once, whether unmapped accesses leave the bank untouched, and whether the read values are correct can only be shown by the bench. It does this by comparing read-back values against its own model after long stalls with changing inputs, back-to-back transfers, unmapped accesses and a mid-run reset.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_HOLD = 1'b1
  } hs_state_e;
endpackage

// File: rtl/dbt_handshake.sv
module dbt_handshake
  import dbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic accept_o,
  output logic ack_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      HS_IDLE: if (req_i)  state_d = HS_HOLD;
      HS_HOLD: if (!req_i) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign accept_o = (state_q == HS_IDLE) && req_i;
  assign ack_o    = (state_q == HS_HOLD);
endmodule

// File: rtl/dbt_regbank.sv
module dbt_regbank #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_REGS-1:0] hit;
  logic [DATA_W-1:0]   regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign hit[i] = (addr_i == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               regs_q[i] <= '0;
      else if (we_i && hit[i])  regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (hit[k]) rd_data_o = rd_data_o | regs_q[k];
    end
  end
endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              accept;
  logic              bank_we;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  dbt_handshake u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .accept_o (accept),
    .ack_o    (ack_o)
  );

  assign bank_we = accept && wr_i;

  dbt_regbank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (bank_we),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rd_data_o (bank_rd)
  );

  assign rdata_en = accept;
  assign rdata_d  = wr_i ? '0 : bank_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dbg_reg_target_chk.sv
module dbg_reg_target_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              ack_o,
  input logic [DATA_W-1:0] rdata_o
);
  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && req_i) |=> ack_o);

  assert_ack_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_i));

  assert_ack_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !ack_o);

  assert_rdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(ack_o)) |-> $stable(rdata_o));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!ack_o && rdata_o == '0);
    end
  end
endmodule

bind dbg_reg_target dbg_reg_target_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .ack_o   (ack_o),
  .rdata_o (rdata_o)
);

// File: tb/dbg_reg_target_bench.sv
module dbg_reg_target_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, wr_i;
  logic [7:0]  addr_i;
  logic [63:0] wdata_i;
  logic        ack_o;
  logic [63:0] rdata_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model [8];

  always #4 clk = ~clk;

  dbg_reg_target u_dbg_reg_target (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic w, input logic [7:0] a, input logic [63:0] d,
                     input int stall, output logic [63:0] rd);
    @(negedge clk);
    req_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d;
    @(negedge clk);
    chk("R2 ack one clock after accept", {63'd0, ack_o}, 64'd1);
    rd = rdata_o;
    for (int k = 0; k < stall; k++) begin
      wdata_i = ~d; addr_i = a ^ 8'h01; wr_i = ~w;
      @(negedge clk);
      chk("R3 ack held during stall", {63'd0, ack_o}, 64'd1);
      chk("R4 rdata stable during ack", rdata_o, rd);
    end
    req_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    @(negedge clk);
    chk("R5 ack low after req low", {63'd0, ack_o}, 64'd0);
    if (w && a < 8) model[a] = d;
  endtask

  task automatic read_all(input string tag);
    logic [63:0] rd;
    for (int i = 0; i < 8; i++) begin
      txn(1'b0, 8'(i), '0, 0, rd);
      chk(tag, rd, model[i]);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 ack low in reset", {63'd0, ack_o}, 64'd0);
    chk("R9 rdata zero in reset", rdata_o, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) model[i] = '0;
    read_all("R9 regs zero after reset");
  endtask

  task automatic t_fill;
    logic [63:0] rd;
    for (int i = 0; i < 8; i++) begin
      txn(1'b1, 8'(i), {8'(i), 56'hA5_5A3C_C3F0_0F17} ^ 64'(i * 3), 0, rd);
      chk("R10 write ack rdata zero", rd, 64'd0);
    end
    read_all("R8 register readback");
  endtask

  task automatic t_unmapped;
    logic [63:0] rd;
    txn(1'b0, 8'h08, '0, 0, rd); chk("R7 unmapped 0x08 reads zero", rd, 64'd0);
    txn(1'b0, 8'hFF, '0, 2, rd); chk("R7 unmapped 0xFF reads zero", rd, 64'd0);
    txn(1'b1, 8'h10, 64'hDEAD_BEEF_0BAD_F00D, 0, rd);
    read_all("R7 unmapped write leaves bank");
  endtask

  task automatic t_stall_write;
    logic [63:0] rd;
    txn(1'b1, 8'd3, 64'h1234_5678_9ABC_DEF0, 50, rd);
    txn(1'b0, 8'd3, '0, 0, rd); chk("R1 single write under stall", rd, model[3]);
    txn(1'b0, 8'd2, '0, 0, rd); chk("R3 neighbour untouched by stall", rd, model[2]);
  endtask

  task automatic t_stall_read;
    logic [63:0] rd;
    txn(1'b0, 8'd5, '0, 40, rd);
    chk("R4 stalled read value", rd, model[5]);
    txn(1'b0, 8'd4, '0, 0, rd); chk("R3 stalled read no side effect", rd, model[4]);
  endtask

  task automatic t_b2b;
    logic [63:0] rd;
    for (int i = 0; i < 8; i++) begin
      txn(1'b1, 8'(7 - i), 64'hF00D_0000_0000_0000 | 64'(i), 0, rd);
      txn(1'b0, 8'(7 - i), '0, 0, rd);
      chk("R6 back-to-back readback", rd, model[7 - i]);
    end
  endtask

  task automatic t_midreset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 ack low mid-run reset", {63'd0, ack_o}, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) model[i] = '0;
    read_all("R9 regs cleared by reset");
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    req_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    t_reset();
    t_fill();
    t_unmapped();
    t_stall_write();
    t_stall_read();
    t_b2b();
    t_midreset();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule